// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block derives the serial clock of a two-wire bus controller from a fast peripheral clock. A 32-bit timing word carries three fields: a prescaler exponent and two zero-based phase counts, one for the low half and one for the high half of the clock. The prescaler divides the peripheral clock by a power of two to form a base tick. The phase sequencer counts ticks to build each low phase and each high phase.

While the run input is high, the generator produces a continuous clock that always starts with a low phase. It reports the base tick, the current SCL level and a strobe on the last cycle of each phase, which a byte engine uses to change SDA. A second strobe marks the middle of each high phase, where SDA is sampled. The timing word is latched when a period starts, so software may rewrite it at any time. Dropping run releases SCL high and clears every counter.

Top module: `scl_timing_gen`

## Requirements
- R1: During reset, and in every cycle after a clock edge at which `run_i` was low, `scl_o` is 1. In the same cases `tick_o`, `bound_o` and `samp_o` are 0. The strobes are also 0 in any cycle in which `run_i` is low.
- R2: While running, `tick_o` pulses for one cycle once every 2^B peripheral clock cycles, where B is `timing_i[3:0]`.
- R3: The low count L is read from `timing_i[12 +: CNT_W]` and the high count H from `timing_i[16 +: CNT_W]`. Every other bit of the word, including `[31:20]` and `[11:4]`, has no effect on the outputs.
- R4: The first cycle after the clock edge that samples `run_i` high from idle is the first cycle of a low phase (`scl_o` = 0). Each low phase lasts (L+1)·2^B cycles.
- R5: Each high phase (`scl_o` = 1) lasts (H+1)·2^B cycles, so one period is (L+H+2)·2^B cycles. A new period begins with a low phase.
- R6: `bound_o` is 1 exactly on the last cycle of each low phase and of each high phase, together with `tick_o`.
- R7: `samp_o` is 1 for one cycle per high phase, at the final cycle of tick number floor(H/2), counting ticks from 0 within that phase.
- R8: The timing word is latched on the first cycle of a run and at the end of each high phase. A change made inside a period does not alter that period.
- R9: When `run_i` drops in the middle of a phase, `scl_o` is 1 in the next cycle. A later restart begins with a full-length low phase.
- R10: The parameter `CNT_W` selects 3-bit or 4-bit phase counts. With `CNT_W` = 4, a field value of 15 gives a phase of 16 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Clock generation enable; low releases SCL and clears the counters |
| timing_i | input | 32 | Timing word: exponent in [3:0], low count at bit 12, high count at bit 16 |
| tick_o | output | 1 | Base tick strobe |
| scl_o | output | 1 | SCL level: 0 in the low phase, 1 in the high phase and when idle |
| bound_o | output | 1 | Strobe on the last cycle of each phase |
| samp_o | output | 1 | Strobe at the middle of each high phase |

## Verification
On every cycle, the assertions check four things. The prescaler count stays within the limit of the current exponent. SCL changes only after a phase-boundary strobe. The sample strobe appears only during a high phase and on a tick. The latched timing stays constant until the period wraps. Only the bench's scenarios can show the exact phase lengths. The same is true of the placement of the mid-high strobe, the field positions in the word, the effect of a rewrite in mid-period, and a full-length low phase after a restart. For these, a behavioural model that tracks the position within the period is compared with the outputs on every cycle.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
    localparam int BASE_W   = 4;
    localparam int BASE_LSB = 0;
    localparam int LO_LSB   = 12;
    localparam int HI_LSB   = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int BASE_W = 4,
    parameter int PRE_W  = (1 << BASE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_regs_t;

    pre_regs_t        s_d, s_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim    = ~({PRE_W{1'b1}} << base_i);
        tick_o = en_i && (s_q.cnt == lim);
        s_d    = s_q;
        if (!en_i || tick_o) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2
    cnt_within_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (s_q.cnt <= lim));

    // R1
    idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             active_o,
    output logic             scl_o,
    output logic             bound_o,
    output logic             samp_o,
    output logic             wrap_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } ph_regs_t;

    ph_regs_t s_d, s_q;
    logic     last;

    always_comb begin
        last     = (s_q.ph == PH_LOW) ? (s_q.cnt == lo_i) : (s_q.cnt == hi_i);
        active_o = (s_q.ph != PH_IDLE);
        scl_o    = (s_q.ph != PH_LOW);
        bound_o  = tick_i && active_o && last;
        wrap_o   = bound_o && (s_q.ph == PH_HIGH);
        samp_o   = tick_i && (s_q.ph == PH_HIGH) && (s_q.cnt == (hi_i >> 1));

        s_d = s_q;
        if (!run_i) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
        end else begin
            case (s_q.ph)
                PH_IDLE: begin
                    s_d.ph  = PH_LOW;
                    s_d.cnt = '0;
                end
                PH_LOW, PH_HIGH: begin
                    if (tick_i) begin
                        if (last) begin
                            s_d.ph  = (s_q.ph == PH_LOW) ? PH_HIGH : PH_LOW;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // R4 R5
    scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && active_o && !bound_o) |=> $stable(scl_o));

    // R6
    bound_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bound_o |=> (scl_o != $past(scl_o)));

    // R1
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (scl_o && !active_o));

    // R7
    samp_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |-> (scl_o && tick_i && active_o));

    // R5
    high_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HIGH) |-> (s_q.cnt <= hi_i));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [WORD_W-1:0] timing_i,
    output logic              tick_o,
    output logic              scl_o,
    output logic              bound_o,
    output logic              samp_o
);
    localparam int PRE_W = (1 << BASE_W) - 1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CNT_W-1:0]  lo;
        logic [CNT_W-1:0]  hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic active;
    logic wrap;
    logic tick;

    always_comb begin
        cfg_d = cfg_q;
        if (!active || wrap) begin
            cfg_d.base = timing_i[BASE_LSB +: BASE_W];
            cfg_d.lo   = timing_i[LO_LSB +: CNT_W];
            cfg_d.hi   = timing_i[HI_LSB +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    scl_prescaler #(
        .BASE_W (BASE_W),
        .PRE_W  (PRE_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run_i && active),
        .base_i (cfg_q.base),
        .tick_o (tick)
    );

    scl_phase_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .tick_i   (tick),
        .lo_i     (cfg_q.lo),
        .hi_i     (cfg_q.hi),
        .active_o (active),
        .scl_o    (scl_o),
        .bound_o  (bound_o),
        .samp_o   (samp_o),
        .wrap_o   (wrap)
    );

    assign tick_o = tick;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && active && !wrap) |=> $stable(cfg_q));

    // R1
    tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> run_i);
endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int CYC_LIMIT  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] tw = '0;
    logic        tick, scl, bound, samp;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    bit m_act = 0;
    int m_pos = 0;
    int m_b = 0, m_lo = 0, m_hi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen #(.CNT_W(CNT_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .timing_i (tw),
        .tick_o   (tick),
        .scl_o    (scl),
        .bound_o  (bound),
        .samp_o   (samp)
    );

    function automatic logic [31:0] mk(int b, int lo, int hi, int junk);
        return 32'(b & 15) | (32'(lo) << 12) | (32'(hi) << 16) | (32'(junk) << 20);
    endfunction

    function automatic int fld(logic [31:0] w, int lsb);
        return int'((w >> lsb) & ((32'd1 << CNT_W) - 1));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic load_cfg();
        m_b  = int'(tw[3:0]);
        m_lo = fld(tw, 12);
        m_hi = fld(tw, 16);
    endtask

    task automatic compare();
        int L, P, e_scl, e_tk, e_bd, e_sp;
        L = 1 << m_b;
        P = (m_lo + m_hi + 2) * L;
        if (!m_act) begin
            chk(scl === 1'b1, "R1 scl idle", int'(scl), 1);
            chk(tick === 1'b0 && bound === 1'b0 && samp === 1'b0, "R1 strobes idle",
                int'({tick, bound, samp}), 0);
        end else begin
            e_scl = (m_pos < L * (m_lo + 1)) ? 0 : 1;
            e_tk  = (run && ((m_pos + 1) % L == 0)) ? 1 : 0;
            e_bd  = (e_tk == 1 && (m_pos + 1 == L * (m_lo + 1) || m_pos + 1 == P)) ? 1 : 0;
            e_sp  = (e_tk == 1 && (m_pos + 1 == L * (m_lo + 1) + L * (m_hi / 2 + 1))) ? 1 : 0;
            chk(scl === 1'(e_scl), "R4 R5 scl", int'(scl), e_scl);
            chk(tick === 1'(e_tk), "R2 tick", int'(tick), e_tk);
            chk(bound === 1'(e_bd), "R6 bound", int'(bound), e_bd);
            chk(samp === 1'(e_sp), "R7 samp", int'(samp), e_sp);
        end
    endtask

    task automatic step();
        int P;
        @(posedge clk);
        P = (m_lo + m_hi + 2) * (1 << m_b);
        if (!rst_n || !run) begin
            m_act = 0;
            m_pos = 0;
        end else if (!m_act) begin
            m_act = 1;
            m_pos = 0;
            load_cfg();
        end else if (m_pos == P - 1) begin
            m_pos = 0;
            load_cfg();
        end else begin
            m_pos++;
        end
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic count_low(int exp, string tag);
        int n = 0;
        while (scl == 1'b0 && cyc < CYC_LIMIT) begin
            n++;
            step();
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic restart(logic [31:0] w);
        run = 1'b0;
        step();
        tw  = w;
        run = 1'b1;
        step();
    endtask

    initial begin
        @(negedge clk);
        steps(3);
        chk(scl === 1'b1, "R1 reset scl", int'(scl), 1);
        rst_n = 1'b1;
        step();

        // R4 R5 R6: minimal period of two cycles
        restart(mk(0, 0, 0, 0));
        steps(12);

        // R2 R7: base exponent 1
        restart(mk(1, 2, 3, 0));
        steps(40);

        // R8: rewrite inside the first low phase, old low count must hold
        restart(mk(0, 5, 2, 0));
        tw = mk(0, 1, 1, 0);
        count_low(6, "R8 low length after mid-period rewrite");
        steps(30);

        // R9: drop run in mid-phase, restart gives full low phase
        restart(mk(1, 3, 2, 0));
        steps(3);
        run = 1'b0;
        step();
        chk(scl === 1'b1, "R9 release after drop", int'(scl), 1);
        run = 1'b1;
        step();
        count_low(8, "R9 full low after restart");
        steps(20);

        // R3: junk in unused bits has no effect
        restart(mk(2, 1, 2, 12'hfff) | 32'h0000_0ff0);
        count_low(8, "R3 low length with junk bits");
        steps(60);

        // R10: four-bit counts reach sixteen ticks
        restart(mk(0, 15, 15, 0));
        count_low(16, "R10 low length at field maximum");
        steps(40);

        // R2: larger exponent
        restart(mk(3, 7, 4, 0));
        steps(150);

        run = 1'b0;
        step();
        steps(2);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, CYC_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule